// File: doc/BRIEF.md
# Hierarchical State-Enable Register Bank

This block holds the state-enable control registers of a hart at three privilege levels: machine, hypervisor and supervisor, four registers per level. Each bit of such a register decides whether software running below that level may touch one piece of extension state. Downstream permission logic receives the effective enable vectors. This block decides nothing about traps. It stores the values, applies the legality and implementation masks, and returns the values through a CSR read/write port.

The levels form a chain. A bit that is clear at machine level reads as zero in the matching hypervisor and supervisor registers. A bit that is clear at hypervisor level hides the matching supervisor bit, but only for accesses made from inside a virtual machine. The lower-level values are stored unmasked by the upper levels. Setting an upper bit again therefore brings back what lower-level software wrote earlier.

The parameter `XLEN` selects 64-bit or 32-bit access. In 32-bit mode the machine and hypervisor registers each gain an upper-half address. The supervisor registers are 32 bits of storage and have no upper half.

Top module: `stateen_csr_bank`

## Requirements
- R1: After the synchronous active-low reset, every stored bit at all three levels is zero, so every read and every enable output is zero.
- R2: With XLEN=64, the machine registers answer at 0x30C+n, the hypervisor registers at 0x60C+n and the supervisor registers at 0x10C+n (n = 0..3). A supervisor read returns its 32 bits zero-extended, so bits 63:32 read as zero.
- R3: A bit is writable only where the implemented mask input is set and the bit is defined. Machine register 0 defines bits 0, 1, 2, 56, 57, 58, 59, 60, 62 and 63 (0xDF00_0000_0000_0007). Hypervisor register 0 defines the same set without bit 56 (0xDE00_0000_0000_0007). Machine and hypervisor registers 1..3 define only bit 63. Supervisor register 0 defines bits 0..2, and supervisor registers 1..3 define none. Every other bit reads as zero.
- R4: A bit that reads zero in machine register n reads as zero in hypervisor register n and in supervisor register n.
- R5: A bit that reads zero in hypervisor register n makes supervisor bit n read as zero when the virtualization input is 1. With the input at 0 the hypervisor value has no effect.
- R6: While the floating-point-present input is 1, bit 1 of machine register 0 reads as zero, and therefore also reads as zero in the lower levels.
- R7: Bit 63 of every hypervisor register can be written even when its implemented-mask bit is clear.
- R8: Upper-level masking acts only on reads and outputs. After an upper bit is set again, the lower-level value written earlier becomes visible again.
- R9: An address outside the map raises the absent output, reads as zero, and a write to it changes no stored bit.
- R10: With XLEN=32, a read or write at 0x30C+n or 0x60C+n covers bits 31:0, and one at 0x31C+n or 0x61C+n covers bits 63:32. A write to one half leaves the other half unchanged. The supervisor upper half at 0x11C+n is absent.
- R11: The outputs show the effective values at all times: the machine value, the hypervisor value masked by machine, the supervisor value masked by machine, and the supervisor value masked by both machine and hypervisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_virt_i | input | 1 | Access comes from a virtual machine (VS view) |
| csr_rdata_o | output | XLEN | Read data for the current address |
| csr_absent_o | output | 1 | Address is not part of this bank |
| m_impl_i | input | N_IDX*64 | Implemented-bit mask, machine registers |
| h_impl_i | input | N_IDX*64 | Implemented-bit mask, hypervisor registers |
| s_impl_i | input | N_IDX*32 | Implemented-bit mask, supervisor registers |
| misa_f_i | input | 1 | Floating-point registers present |
| m_en_o | output | N_IDX*64 | Effective machine enables |
| h_en_o | output | N_IDX*64 | Effective hypervisor enables |
| s_en_o | output | N_IDX*32 | Effective supervisor enables, host view |
| vs_en_o | output | N_IDX*32 | Effective supervisor enables, guest view |

## Verification
The hardest case is a supervisor bit that is stored as one but hidden because the hypervisor copy is clear. This differs between the host view and the guest view, and the value must come back once the upper bit is set again. The stimulus first opens all three levels. It then clears single upper bits in the machine and hypervisor registers, reads the supervisor register with the virtualization input both low and high, and sets the upper bit again to show that the stored value returns. A separate 32-bit instance checks that each half can be written on its own.

// File: rtl/stateen_pkg.sv
// Package: shared constants, types and bit-legality functions for the
// state-enable register bank. Assumes four registers per level.
package stateen_pkg;

    localparam logic [11:0] ADDR_M_LO = 12'h30C;
    localparam logic [11:0] ADDR_M_HI = 12'h31C;
    localparam logic [11:0] ADDR_H_LO = 12'h60C;
    localparam logic [11:0] ADDR_H_HI = 12'h61C;
    localparam logic [11:0] ADDR_S_LO = 12'h10C;

    localparam logic [63:0] BIT_SE      = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MACH0_DEF   = 64'hDF00_0000_0000_0007;
    localparam logic [63:0] HYP0_DEF    = 64'hDE00_0000_0000_0007;
    localparam logic [31:0] SUP0_DEF    = 32'h0000_0007;
    localparam logic [63:0] FP_CTRL_BIT = 64'h0000_0000_0000_0002;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_MACH = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_SUP  = 2'd3
    } lvl_e;

    typedef struct packed {
        lvl_e       lvl;
        logic       upper;
        logic [1:0] idx;
    } csr_sel_t;

    // Defined bits of machine register idx
    function automatic logic [63:0] mach_defined(input int idx);
        return (idx == 0) ? MACH0_DEF : BIT_SE;
    endfunction

    // Defined bits of hypervisor register idx
    function automatic logic [63:0] hyp_defined(input int idx);
        return (idx == 0) ? HYP0_DEF : BIT_SE;
    endfunction

    // Defined bits of supervisor register idx
    function automatic logic [31:0] sup_defined(input int idx);
        return (idx == 0) ? SUP0_DEF : 32'h0;
    endfunction

endpackage

// File: rtl/stateen_decode.sv
// Address decoder: maps a 12-bit CSR address to a level, register index
// and half. Upper-half addresses exist only when XLEN is 32. Assumes
// N_IDX <= 4 (two index bits).
module stateen_decode
    import stateen_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int N_IDX = 4
) (
    input  logic [11:0] addr_i,
    output csr_sel_t    sel_o
);

    logic [11:0] base;
    logic        idx_ok;

    // Classify the address into level, half and index
    always_comb begin
        base   = {addr_i[11:2], 2'b00};
        idx_ok = (int'(addr_i[1:0]) < N_IDX);
        sel_o  = '{lvl: LVL_NONE, upper: 1'b0, idx: addr_i[1:0]};
        if (idx_ok) begin
            if (base == ADDR_M_LO) begin
                sel_o.lvl = LVL_MACH;
            end else if (base == ADDR_H_LO) begin
                sel_o.lvl = LVL_HYP;
            end else if (base == ADDR_S_LO) begin
                sel_o.lvl = LVL_SUP;
            end else if ((XLEN == 32) && (base == ADDR_M_HI)) begin
                sel_o.lvl   = LVL_MACH;
                sel_o.upper = 1'b1;
            end else if ((XLEN == 32) && (base == ADDR_H_HI)) begin
                sel_o.lvl   = LVL_HYP;
                sel_o.upper = 1'b1;
            end
        end
    end

endmodule

// File: rtl/stateen_reg.sv
// One state-enable storage register. A write merges the write lanes into
// the old value and keeps only the writable bits. Assumes the writable
// mask changes only between writes.
module stateen_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] lane_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] wmask_i,
    output logic [W-1:0] q_o
);

    // Storage with lane merge and legality mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (we_i) begin
            q_o <= ((q_o & ~lane_i) | (wdata_i & lane_i)) & wmask_i;
        end
    end

    // R1: register is clear on the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q_o == '0));

    // R3: a write leaves no bit set outside the writable mask
    p_ro_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((q_o & ~$past(wmask_i)) == '0));

    // R9: without a write the register holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> (q_o == $past(q_o)));

endmodule

// File: rtl/stateen_view.sv
// Effective-value chain: applies the floating-point override to machine
// register 0, then masks hypervisor values by machine values and the
// supervisor values by machine (host view) and also by hypervisor
// (guest view). Purely combinational.
module stateen_view
    import stateen_pkg::*;
#(
    parameter int N_IDX = 4
) (
    input  logic [N_IDX*64-1:0] m_raw_i,
    input  logic [N_IDX*64-1:0] h_raw_i,
    input  logic [N_IDX*32-1:0] s_raw_i,
    input  logic                misa_f_i,
    output logic [N_IDX*64-1:0] m_eff_o,
    output logic [N_IDX*64-1:0] h_eff_o,
    output logic [N_IDX*32-1:0] s_hs_o,
    output logic [N_IDX*32-1:0] s_vs_o
);

    for (genvar i = 0; i < N_IDX; i++) begin : g_idx
        localparam logic [63:0] FP_KILL = (i == 0) ? FP_CTRL_BIT : 64'h0;
        logic [63:0] m_e;
        logic [63:0] h_e;

        // Machine value with the floating-point override
        assign m_e = m_raw_i[i*64 +: 64] & ~(misa_f_i ? FP_KILL : 64'h0);
        // Hypervisor value under the machine gate
        assign h_e = h_raw_i[i*64 +: 64] & m_e;

        assign m_eff_o[i*64 +: 64] = m_e;
        assign h_eff_o[i*64 +: 64] = h_e;
        // Supervisor value, host view and guest view
        assign s_hs_o[i*32 +: 32]  = s_raw_i[i*32 +: 32] & m_e[31:0];
        assign s_vs_o[i*32 +: 32]  = s_raw_i[i*32 +: 32] & m_e[31:0] & h_e[31:0];
    end

endmodule

// File: rtl/stateen_csr_bank.sv
// Top: state-enable register bank with three levels of N_IDX registers.
// Decodes the CSR address, forms the write lanes for 64-bit or split
// 32-bit access, stores the values masked by legality and implementation,
// and returns read data and effective enables through the view chain.
// Assumes XLEN is 32 or 64 and the mask inputs are quasi-static.
module stateen_csr_bank
    import stateen_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int N_IDX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         csr_addr_i,
    input  logic                csr_we_i,
    input  logic [XLEN-1:0]     csr_wdata_i,
    input  logic                csr_virt_i,
    output logic [XLEN-1:0]     csr_rdata_o,
    output logic                csr_absent_o,
    input  logic [N_IDX*64-1:0] m_impl_i,
    input  logic [N_IDX*64-1:0] h_impl_i,
    input  logic [N_IDX*32-1:0] s_impl_i,
    input  logic                misa_f_i,
    output logic [N_IDX*64-1:0] m_en_o,
    output logic [N_IDX*64-1:0] h_en_o,
    output logic [N_IDX*32-1:0] s_en_o,
    output logic [N_IDX*32-1:0] vs_en_o
);

    localparam int MW = 64;
    localparam int SW = 32;

    csr_sel_t            sel;
    logic [MW-1:0]       wd64;
    logic [MW-1:0]       lane64;
    logic [SW-1:0]       wd32;
    logic [MW-1:0]       rd64;
    logic [N_IDX*MW-1:0] m_raw;
    logic [N_IDX*MW-1:0] h_raw;
    logic [N_IDX*SW-1:0] s_raw;
    logic [N_IDX-1:0]    we_m;
    logic [N_IDX-1:0]    we_h;
    logic [N_IDX-1:0]    we_s;
    logic [MW-1:0]       m_eff_a [N_IDX];
    logic [MW-1:0]       h_eff_a [N_IDX];
    logic [SW-1:0]       s_hs_a  [N_IDX];
    logic [SW-1:0]       s_vs_a  [N_IDX];

    stateen_decode #(.XLEN(XLEN), .N_IDX(N_IDX)) u_dec (
        .addr_i (csr_addr_i),
        .sel_o  (sel)
    );

    assign csr_absent_o = (sel.lvl == LVL_NONE);

    // Write lane formation depends on the access width
    if (XLEN == 64) begin : g_w64
        assign wd64   = csr_wdata_i;
        assign lane64 = '1;
        assign wd32   = csr_wdata_i[31:0];
    end else begin : g_w32
        assign wd64   = sel.upper ? {csr_wdata_i, 32'h0} : {32'h0, csr_wdata_i};
        assign lane64 = sel.upper ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
        assign wd32   = csr_wdata_i;
    end

    for (genvar i = 0; i < N_IDX; i++) begin : g_reg
        logic [MW-1:0] m_wm;
        logic [MW-1:0] h_wm;
        logic [SW-1:0] s_wm;

        // Per-register strobes and writable masks
        assign we_m[i] = csr_we_i && (sel.lvl == LVL_MACH) && (int'(sel.idx) == i);
        assign we_h[i] = csr_we_i && (sel.lvl == LVL_HYP)  && (int'(sel.idx) == i);
        assign we_s[i] = csr_we_i && (sel.lvl == LVL_SUP)  && (int'(sel.idx) == i);
        assign m_wm    = m_impl_i[i*MW +: MW] & mach_defined(i);
        assign h_wm    = (h_impl_i[i*MW +: MW] & hyp_defined(i)) | BIT_SE;
        assign s_wm    = s_impl_i[i*SW +: SW] & sup_defined(i);

        stateen_reg #(.W(MW)) u_m (
            .clk(clk), .rst_n(rst_n), .we_i(we_m[i]), .lane_i(lane64),
            .wdata_i(wd64), .wmask_i(m_wm), .q_o(m_raw[i*MW +: MW])
        );
        stateen_reg #(.W(MW)) u_h (
            .clk(clk), .rst_n(rst_n), .we_i(we_h[i]), .lane_i(lane64),
            .wdata_i(wd64), .wmask_i(h_wm), .q_o(h_raw[i*MW +: MW])
        );
        stateen_reg #(.W(SW)) u_s (
            .clk(clk), .rst_n(rst_n), .we_i(we_s[i]), .lane_i('1),
            .wdata_i(wd32), .wmask_i(s_wm), .q_o(s_raw[i*SW +: SW])
        );

        assign m_eff_a[i] = m_en_o[i*MW +: MW];
        assign h_eff_a[i] = h_en_o[i*MW +: MW];
        assign s_hs_a[i]  = s_en_o[i*SW +: SW];
        assign s_vs_a[i]  = vs_en_o[i*SW +: SW];

        // R7: hypervisor bit 63 takes a written one regardless of the mask
        p_se_writable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (we_h[i] && lane64[63] && wd64[63]) |=> h_raw[i*MW + 63]);
    end

    stateen_view #(.N_IDX(N_IDX)) u_view (
        .m_raw_i  (m_raw),
        .h_raw_i  (h_raw),
        .s_raw_i  (s_raw),
        .misa_f_i (misa_f_i),
        .m_eff_o  (m_en_o),
        .h_eff_o  (h_en_o),
        .s_hs_o   (s_en_o),
        .s_vs_o   (vs_en_o)
    );

    // Read multiplexer over the effective views
    always_comb begin
        rd64 = '0;
        case (sel.lvl)
            LVL_MACH: rd64 = m_eff_a[sel.idx];
            LVL_HYP:  rd64 = h_eff_a[sel.idx];
            LVL_SUP:  rd64 = {32'h0, (csr_virt_i ? s_vs_a[sel.idx] : s_hs_a[sel.idx])};
            default:  rd64 = '0;
        endcase
    end

    // Return the full word or the addressed half
    if (XLEN == 64) begin : g_r64
        assign csr_rdata_o = rd64;
    end else begin : g_r32
        assign csr_rdata_o = sel.upper ? rd64[63:32] : rd64[31:0];
    end

    // R9: a write to an absent address leaves all storage unchanged
    p_absent_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_absent_o) |=>
            ((m_raw == $past(m_raw)) && (h_raw == $past(h_raw)) && (s_raw == $past(s_raw))));

    // R5: guest-view supervisor reads never show a bit the hypervisor hides
    p_vs_hide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_virt_i && (sel.lvl == LVL_SUP)) |->
            ((csr_rdata_o[31:0] & ~h_en_o[sel.idx*64 +: 32]) == 32'h0));

    // R6: machine register 0 low half shows bit 1 clear while F is present
    p_fcsr_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (misa_f_i && (sel.lvl == LVL_MACH) && (sel.idx == 2'd0) && !sel.upper) |->
            !csr_rdata_o[1]);

    // R9: absent addresses read as zero
    p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_absent_o |-> (csr_rdata_o == '0));

endmodule

// File: tb/tb_stateen_csr_bank.sv
module tb_stateen_csr_bank;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [11:0]   addr;
    logic          we;
    logic [63:0]   wdata;
    logic          virt;
    logic [63:0]   rdata;
    logic          absent;
    logic [255:0]  m_impl;
    logic [255:0]  h_impl;
    logic [127:0]  s_impl;
    logic          misa_f;
    logic [255:0]  m_en;
    logic [255:0]  h_en;
    logic [127:0]  s_en;
    logic [127:0]  vs_en;

    logic [11:0]   addr32;
    logic          we32;
    logic [31:0]   wdata32;
    logic [31:0]   rdata32;
    logic          absent32;
    logic [255:0]  m_en32;
    logic [255:0]  h_en32;
    logic [127:0]  s_en32;
    logic [127:0]  vs_en32;

    int checks = 0;
    int errors = 0;
    logic mon_on = 1'b0;

    logic [63:0] mm [4];
    logic [63:0] hh [4];
    logic [31:0] ss [4];

    stateen_csr_bank #(.XLEN(64), .N_IDX(4)) dut (
        .clk(clk), .rst_n(rst_n), .csr_addr_i(addr), .csr_we_i(we),
        .csr_wdata_i(wdata), .csr_virt_i(virt), .csr_rdata_o(rdata),
        .csr_absent_o(absent), .m_impl_i(m_impl), .h_impl_i(h_impl),
        .s_impl_i(s_impl), .misa_f_i(misa_f), .m_en_o(m_en), .h_en_o(h_en),
        .s_en_o(s_en), .vs_en_o(vs_en)
    );

    stateen_csr_bank #(.XLEN(32), .N_IDX(4)) dut32 (
        .clk(clk), .rst_n(rst_n), .csr_addr_i(addr32), .csr_we_i(we32),
        .csr_wdata_i(wdata32), .csr_virt_i(1'b0), .csr_rdata_o(rdata32),
        .csr_absent_o(absent32), .m_impl_i({256{1'b1}}), .h_impl_i({256{1'b1}}),
        .s_impl_i({128{1'b1}}), .misa_f_i(1'b0), .m_en_o(m_en32), .h_en_o(h_en32),
        .s_en_o(s_en32), .vs_en_o(vs_en32)
    );

    function automatic logic [63:0] def_m(int i);
        return (i == 0) ? 64'hDF00_0000_0000_0007 : 64'h8000_0000_0000_0000;
    endfunction
    function automatic logic [63:0] def_h(int i);
        return (i == 0) ? 64'hDE00_0000_0000_0007 : 64'h8000_0000_0000_0000;
    endfunction
    function automatic logic [31:0] def_s(int i);
        return (i == 0) ? 32'h7 : 32'h0;
    endfunction

    // Expected {absent, data} for an address and view
    function automatic logic [64:0] exp_rd(logic [11:0] a, logic v);
        int i;
        logic [63:0] me, he;
        logic [31:0] sv;
        i  = int'(a[1:0]);
        me = mm[i] & ((i == 0 && misa_f) ? ~64'h2 : ~64'h0);
        he = hh[i] & me;
        sv = ss[i] & me[31:0];
        if (v) sv = sv & he[31:0];
        case ({a[11:2], 2'b00})
            12'h30C: return {1'b0, me};
            12'h60C: return {1'b0, he};
            12'h10C: return {1'b0, 32'h0, sv};
            default: return {1'b1, 64'h0};
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d);
        int i;
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0;
        i = int'(a[1:0]);
        case ({a[11:2], 2'b00})
            12'h30C: mm[i] = d & m_impl[i*64 +: 64] & def_m(i);
            12'h60C: hh[i] = d & ((h_impl[i*64 +: 64] & def_h(i)) | 64'h8000_0000_0000_0000);
            12'h10C: ss[i] = d[31:0] & s_impl[i*32 +: 32] & def_s(i);
            default: ;
        endcase
    endtask

    task automatic rd(string req, logic [11:0] a, logic v);
        logic [64:0] e;
        @(negedge clk);
        addr = a; virt = v;
        #1;
        e = exp_rd(a, v);
        chk(req, rdata, e[63:0]);
        chk(req, {63'h0, absent}, {63'h0, e[64]});
    endtask

    task automatic wr32(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr32 = a; wdata32 = d; we32 = 1'b1;
        @(posedge clk);
        #1;
        we32 = 1'b0;
    endtask

    task automatic rd32(string req, logic [11:0] a, logic [31:0] exp, logic exp_abs);
        @(negedge clk);
        addr32 = a;
        #1;
        chk(req, {32'h0, rdata32}, {32'h0, exp});
        chk(req, {63'h0, absent32}, {63'h0, exp_abs});
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // R11: effective outputs compared with the model every cycle
    always begin
        @(negedge clk);
        #2;
        if (mon_on && rst_n) begin
            for (int i = 0; i < 4; i++) begin
                logic [64:0] t;
                t = exp_rd(12'h30C + 12'(i), 1'b0);
                chk("R11 m", m_en[i*64 +: 64], t[63:0]);
                t = exp_rd(12'h60C + 12'(i), 1'b0);
                chk("R11 h", h_en[i*64 +: 64], t[63:0]);
                t = exp_rd(12'h10C + 12'(i), 1'b0);
                chk("R11 s", {32'h0, s_en[i*32 +: 32]}, t[63:0]);
                t = exp_rd(12'h10C + 12'(i), 1'b1);
                chk("R11 vs", {32'h0, vs_en[i*32 +: 32]}, t[63:0]);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; addr = 12'h0; we = 1'b0; wdata = '0; virt = 1'b0;
        m_impl = '1; h_impl = '1; s_impl = '1; misa_f = 1'b0;
        addr32 = 12'h0; we32 = 1'b0; wdata32 = '0;
        for (int i = 0; i < 4; i++) begin
            mm[i] = '0; hh[i] = '0; ss[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: everything zero after reset
        for (int i = 0; i < 4; i++) begin
            rd("R1", 12'h30C + 12'(i), 1'b0);
            rd("R1", 12'h60C + 12'(i), 1'b0);
            rd("R1", 12'h10C + 12'(i), 1'b0);
        end

        // R2/R3: fill all levels with ones, read back legal bits
        for (int i = 0; i < 4; i++) wr(12'h30C + 12'(i), '1);
        for (int i = 0; i < 4; i++) wr(12'h60C + 12'(i), '1);
        for (int i = 0; i < 4; i++) wr(12'h10C + 12'(i), '1);
        for (int i = 0; i < 4; i++) begin
            rd("R2 R3", 12'h30C + 12'(i), 1'b0);
            rd("R2 R3", 12'h60C + 12'(i), 1'b0);
            rd("R2 R3", 12'h10C + 12'(i), 1'b0);
        end
        rd("R3", 12'h30C, 1'b0);
        chk("R3 m0 literal", rdata, 64'hDF00_0000_0000_0007);
        rd("R3", 12'h60C, 1'b0);
        chk("R3 h0 literal", rdata, 64'hDE00_0000_0000_0007);

        // R5: clear hypervisor low bits; guest view hides, host view keeps
        wr(12'h60C, 64'h8000_0000_0000_0005);
        rd("R5", 12'h10C, 1'b1);
        chk("R5 vs literal", rdata, 64'h5);
        rd("R5", 12'h10C, 1'b0);
        chk("R5 hs literal", rdata, 64'h7);

        // R4: clear machine bit 0, lower levels lose it
        wr(12'h30C, 64'hFFFF_FFFF_FFFF_FFFE);
        rd("R4", 12'h60C, 1'b0);
        rd("R4", 12'h10C, 1'b0);
        chk("R4 hs literal", rdata, 64'h6);

        // R8: set machine bit again, lower value returns
        wr(12'h30C, '1);
        rd("R8", 12'h10C, 1'b0);
        chk("R8 literal", rdata, 64'h7);
        wr(12'h60C, '1);
        rd("R8", 12'h10C, 1'b1);
        chk("R8 vs literal", rdata, 64'h7);

        // R6: floating point present hides bit 1 down the chain
        @(negedge clk); misa_f = 1'b1;
        rd("R6", 12'h30C, 1'b0);
        rd("R6", 12'h10C, 1'b0);
        chk("R6 literal", rdata, 64'h5);
        @(negedge clk); misa_f = 1'b0;
        rd("R6 R8", 12'h10C, 1'b0);

        // R7: hypervisor bit 63 writable with mask cleared
        @(negedge clk); h_impl = '0;
        wr(12'h60D, 64'h0);
        wr(12'h60D, '1);
        rd("R7", 12'h60D, 1'b0);
        chk("R7 literal", rdata, 64'h8000_0000_0000_0000);
        wr(12'h60C, '1);
        rd("R7", 12'h60C, 1'b0);
        @(negedge clk); h_impl = '1;

        // R3: partial machine implementation mask
        @(negedge clk); m_impl[63:0] = 64'h0000_0000_0000_0005;
        wr(12'h30C, '1);
        rd("R3", 12'h30C, 1'b0);
        rd("R3 R4", 12'h10C, 1'b0);
        @(negedge clk); m_impl = '1;
        wr(12'h30C, '1);

        // R9: absent addresses, writes ignored
        rd("R9", 12'h30B, 1'b0);
        rd("R9", 12'h310, 1'b0);
        rd("R9", 12'h31C, 1'b0);
        rd("R9", 12'h11C, 1'b0);
        wr(12'h310, 64'h0);
        wr(12'h61C, 64'h0);
        wr(12'h11C, 64'h0);
        rd("R9", 12'h30C, 1'b0);
        rd("R9", 12'h60C, 1'b0);
        rd("R9", 12'h10C, 1'b0);

        // R10: 32-bit instance, split halves
        wr32(12'h30C, 32'hFFFF_FFFF);
        wr32(12'h31C, 32'hFFFF_FFFF);
        rd32("R10", 12'h30C, 32'h0000_0007, 1'b0);
        rd32("R10", 12'h31C, 32'hDF00_0000, 1'b0);
        wr32(12'h61C, 32'hFFFF_FFFF);
        rd32("R10", 12'h61C, 32'hDE00_0000, 1'b0);
        rd32("R10", 12'h11C, 32'h0, 1'b1);
        wr32(12'h31C, 32'h0);
        rd32("R10", 12'h30C, 32'h0000_0007, 1'b0);
        rd32("R10 R4", 12'h61C, 32'h0, 1'b0);
        wr32(12'h31C, 32'hFFFF_FFFF);
        rd32("R10 R8", 12'h61C, 32'hDE00_0000, 1'b0);

        repeat (2) @(negedge clk);
        mon_on = 1'b0;
        summary();
    end

endmodule